// File: doc/BRIEF.md
# Daughterboard Reference Clock Generator

This block derives a slow, square reference clock from the master clock and hands it to an add-on board through the first pin of that board's general-purpose I/O bank. A single control word, loaded by a write strobe, carries a divisor field and an enable bit. While a clock is being produced, the block takes pin 0 over and raises an override flag so that the direction logic can force that pin to be an output. When no clock is wanted, pin 0 carries the ordinary I/O value supplied to the block.

The clock period is twice the divisor, counted in master clock cycles, with equal low and high halves. Every write to the control word restarts the divider, so the first half-period after any write is always the low half. A zero divisor counts as "off" even when the enable bit is set.

Top module: `aux_refclk_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pin0_out` and `pin0_override` are both 0.
- R2: On a cycle with `cfg_wr` high, bit 7 of `cfg_wdata` is taken as the enable and bits 6:0 as the divisor D; bits 31:8 are ignored, so a word with nonzero upper bits behaves exactly as the same word with those bits cleared.
- R3: After a write with enable 1 and D nonzero at clock edge E0, `pin0_override` is 1 from edge E1 on, until a later write turns the clock off.
- R4: With the clock running, counting edges from E1 after the write at E0, `pin0_out` after edge E1+n equals floor(n / D) mod 2: D cycles low, D cycles high, period 2·D.
- R5: A write with D equal to 0 turns the clock off regardless of the enable bit.
- R6: While the clock is off, `pin0_override` is 0 and `pin0_out` after each edge equals the value `io_pin0` had at that edge.
- R7: Any write, including one that repeats the current word, restarts the waveform in its low half, one edge after the write.
- R8: `pin0_override` is 1 exactly in the cycles in which `pin0_out` carries the generated clock.
- R9: With `cfg_wr` low, `cfg_wdata` has no effect: the stored enable and divisor, and so the outputs, are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: bit 7 enable, bits 6:0 divisor, bits 31:8 reserved |
| io_pin0 | input | 1 | Ordinary output value for I/O pin 0 |
| pin0_out | output | 1 | Value driven onto I/O pin 0 |
| pin0_override | output | 1 | High while pin 0 carries the generated clock |

## Verification
A stale divide counter or a toggle flip-flop left in the wrong phase shows at `pin0_out` as a first half-period that starts high or runs longer or shorter than D cycles, visible within 2·D cycles of the write. A wrongly stored enable or divisor shows one edge after the write as a wrong `pin0_override` level, and a missed off-state shows as `pin0_out` failing to follow `io_pin0` on the very next edge. The bench compares both outputs against a behavioural edge-counting model on every cycle, so any such error is reported in the cycle it first appears.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
   // default layout of the control word
   localparam int REFCLK_CTRL_W  = 32;
   localparam int REFCLK_DIV_W   = 7;
   localparam int REFCLK_EN_POS  = 7;

   // phase of the generated clock
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } refclk_phase_e;
endpackage

// File: rtl/refclk_ctrl_reg.sv
module refclk_ctrl_reg
   import refclk_pkg::*;
#(
   parameter int CTRL_W = REFCLK_CTRL_W,
   parameter int DIV_W  = REFCLK_DIV_W,
   parameter int EN_POS = REFCLK_EN_POS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output logic [DIV_W-1:0]  div,
   output logic              active
);
   logic en_q;
   logic [DIV_W-1:0] div_q;

   // only the enable and divisor fields are stored; the rest is dropped
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         div_q <= '0;
      end else if (wr) begin
         en_q  <= wdata[EN_POS];
         div_q <= wdata[DIV_W-1:0];
      end
   end

   assign div    = div_q;
   assign active = en_q && (div_q != '0);
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
   import refclk_pkg::*;
#(
   parameter int DIV_W = REFCLK_DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             active,
   input  logic [DIV_W-1:0] div,
   output refclk_phase_e    phase
);
   logic [DIV_W-1:0] cnt_q;
   refclk_phase_e    phase_q;
   logic             last_tick;

   assign last_tick = (cnt_q == div - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || restart || !active) begin
         cnt_q   <= '0;
         phase_q <= PH_LOW;
      end else if (last_tick) begin
         cnt_q   <= '0;
         phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
      end else begin
         cnt_q   <= cnt_q + DIV_W'(1);
      end
   end

   assign phase = phase_q;
endmodule

// File: rtl/refclk_pin_mux.sv
module refclk_pin_mux
   import refclk_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  refclk_phase_e phase,
   input  logic          io_val,
   output logic          pin_out,
   output logic          override
);
   // registered so the pin and its flag change on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_out  <= 1'b0;
         override <= 1'b0;
      end else begin
         pin_out  <= active ? (phase == PH_HIGH) : io_val;
         override <= active;
      end
   end
endmodule

// File: rtl/aux_refclk_gen.sv
module aux_refclk_gen
   import refclk_pkg::*;
#(
   parameter int CTRL_W = REFCLK_CTRL_W,
   parameter int DIV_W  = REFCLK_DIV_W,
   parameter int EN_POS = REFCLK_EN_POS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CTRL_W-1:0] cfg_wdata,
   input  logic              io_pin0,
   output logic              pin0_out,
   output logic              pin0_override
);
   localparam int FIELD_TOP = (EN_POS > DIV_W - 1) ? EN_POS : DIV_W - 1;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("divisor field must be at least one bit wide");
      end
      if (EN_POS < DIV_W) begin : g_bad_en
         $error("enable bit overlaps the divisor field");
      end
      if (FIELD_TOP >= CTRL_W) begin : g_bad_ctrl
         $error("control word too narrow for its fields");
      end
   endgenerate

   logic [DIV_W-1:0] div;
   logic             active;
   refclk_phase_e    phase;

   refclk_ctrl_reg #(.CTRL_W(CTRL_W), .DIV_W(DIV_W), .EN_POS(EN_POS)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (cfg_wr),
      .wdata  (cfg_wdata),
      .div    (div),
      .active (active)
   );

   refclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cfg_wr),
      .active  (active),
      .div     (div),
      .phase   (phase)
   );

   refclk_pin_mux u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .phase    (phase),
      .io_val   (io_pin0),
      .pin_out  (pin0_out),
      .override (pin0_override)
   );
endmodule

// File: rtl/refclk_gen_checker.sv
module refclk_gen_checker #(
   parameter int CTRL_W = 32,
   parameter int DIV_W  = 7,
   parameter int EN_POS = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [CTRL_W-1:0] cfg_wdata,
   input logic              io_pin0,
   input logic              pin0_out,
   input logic              pin0_override
);
   logic primed;
   always_ff @(posedge clk) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!pin0_out && !pin0_override));

   assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wdata[EN_POS] && (cfg_wdata[DIV_W-1:0] != '0))
      |=> ##1 pin0_override);

   assert_zero_div_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && (cfg_wdata[DIV_W-1:0] == '0)) |=> ##1 !pin0_override);

   assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !pin0_override) |-> (pin0_out == $past(io_pin0)));

   assert_low_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> ##1 (!pin0_override || !pin0_out));

   assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !cfg_wr) |=> ##1 $stable(pin0_override));
endmodule

bind aux_refclk_gen refclk_gen_checker #(
   .CTRL_W(CTRL_W), .DIV_W(DIV_W), .EN_POS(EN_POS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_wr        (cfg_wr),
   .cfg_wdata     (cfg_wdata),
   .io_pin0       (io_pin0),
   .pin0_out      (pin0_out),
   .pin0_override (pin0_override)
);

// File: tb/tb_aux_refclk_gen.sv
`timescale 1ns/1ps
module tb_aux_refclk_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        io_pin0 = 1'b0;
   logic        pin0_out;
   logic        pin0_override;

   always #10 clk = ~clk;

   aux_refclk_gen dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .io_pin0(io_pin0), .pin0_out(pin0_out), .pin0_override(pin0_override)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural model: stored fields plus edges seen since the last write
   int m_en = 0, m_div = 0, m_since = 0;
   int exp_pin = 0, exp_ovr = 0;
   string cur_req = "R1";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_div = 0; m_since = 0; exp_pin = 0; exp_ovr = 0;
      end else begin
         if (m_en != 0 && m_div != 0) begin
            exp_ovr = 1;
            exp_pin = (m_since / m_div) % 2;
            m_since = m_since + 1;
         end else begin
            exp_ovr = 0;
            exp_pin = int'(io_pin0);
         end
         if (cfg_wr) begin
            m_en    = int'(cfg_wdata[7]);
            m_div   = int'(cfg_wdata[6:0]);
            m_since = 0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
      end
   endtask

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         check(int'(pin0_override) == exp_ovr, {cur_req, " override (R8)"},
               int'(pin0_override), exp_ovr);
         check(int'(pin0_out) == exp_pin, {cur_req, " pin0"}, int'(pin0_out), exp_pin);
      end
   end

   task automatic idle(input int n, input bit wiggle);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cfg_wr = 1'b0;
         if (wiggle) begin
            io_pin0   = $urandom_range(0, 1) != 0;
            cfg_wdata = $urandom;
         end
      end
   endtask

   task automatic write_word(input logic [31:0] w);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_wdata = w;
      @(negedge clk);
      cfg_wr    = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic summary;
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(4, 1'b1);                       // R6 pass-through after reset
      cur_req = "R6";
      idle(20, 1'b1);
      cur_req = "R3_R4";
      write_word(32'h0000_0081);           // enable, D=1
      idle(12, 1'b1);
      write_word(32'h0000_0083);           // enable, D=3
      idle(30, 1'b0);
      cur_req = "R4";
      write_word(32'h0000_00FF);           // enable, D=127 (largest)
      idle(300, 1'b0);
      cur_req = "R2";
      write_word(32'hA5C3_F082);           // reserved bits set, enable, D=2
      idle(20, 1'b0);
      cur_req = "R9";
      idle(25, 1'b1);                      // data bus changes without strobe
      cur_req = "R7";
      write_word(32'h0000_0085);           // D=5
      idle(7, 1'b0);                       // now inside the high half
      write_word(32'h0000_0085);           // same word again: restart low
      idle(25, 1'b0);
      cur_req = "R5";
      write_word(32'h0000_0080);           // enable with D=0
      idle(20, 1'b1);
      cur_req = "R6";
      write_word(32'h0000_0004);           // disabled, D=4
      idle(20, 1'b1);
      cur_req = "R3";
      write_word(32'h0000_0082);
      write_word(32'h0000_0000);           // back-to-back off
      idle(10, 1'b1);
      cur_req = "R1";
      @(negedge clk); rst_n = 1'b0;
      write_word(32'h0000_0081);           // ignored under reset
      idle(3, 1'b1);
      rst_n = 1'b1;
      idle(10, 1'b1);
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule